// File: doc/BRIEF.md
# MMU Fault Entry Controller

This block sits beside a set-associative translation buffer and turns the result of a data-access lookup into a complete hardware exception entry. Every cycle it sees the access (virtual address, read or write, current address-space ID), the per-way compare and valid flags from the lookup, and the CPU context: program counter, status word and vector base. When the lookup shows a fault, it records the fault in its own registers in one clock edge and asks the fetch stage to jump to the handler.

There are two kinds of fault. A miss means no way's tag compared equal. An invalid-entry fault means a way compared equal but its entry is marked not valid. Both faults capture the faulting address, build the page-table-entry-high image, save the PC and status word, write a direction-dependent event code and force the privilege bits of the status word to 1. They differ in the handler vector they select and in how they move the way-replacement counter.

A power-on reset (`rst_n`), a manual reset request and a debug-port reset request all return the status word to its privileged state and the replacement counter to way 0.

Top module: `mmu_fault_entry`

## Requirements
- R1: While `rst_n` is low, and one rising edge after `man_rst` or `dbg_rst` is sampled high, `sr_out` equals 0x7000_0000 (bit 30 MD, bit 29 RB and bit 28 BL set, all other bits 0), `repl_ctr` is 0 and `redirect_valid` is 0. A reset request has priority over a fault in the same cycle.
- R2: A miss is an access with `acc_valid` high and `way_match` all zero. One edge later `redirect_valid` is high for one cycle and `redirect_pc` equals `vec_base` + 0x400.
- R3: An invalid-entry fault is an access with `acc_valid` high, at least one `way_match` bit set and no way with both match and valid set. One edge later `redirect_valid` is high for one cycle and `redirect_pc` equals `vec_base` + 0x100.
- R4: On either fault, `fault_addr` receives all 32 bits of `acc_vaddr`.
- R5: On either fault, `pteh` receives `acc_vaddr[31:10]` in bits 31..10, zeros in bits 9..8 and `cur_asid` in bits 7..0.
- R6: On either fault, `saved_pc` receives `cur_pc` and `saved_sr` receives `cur_sr`.
- R7: On either fault, `event_code` is loaded with 0x040 when `acc_write` is 0 and 0x060 when `acc_write` is 1.
- R8: On either fault, `sr_out` is loaded with `cur_sr` with bits 30, 29 and 28 forced to 1.
- R9: On a miss with all four `way_valid` bits set, `repl_ctr` increments by one, wrapping from 3 to 0.
- R10: On a miss with any `way_valid` bit clear, `repl_ctr` is loaded with the lowest index whose valid bit is clear (way 0 has top priority).
- R11: On an invalid-entry fault, `repl_ctr` is loaded with the index of the matching way (lowest index if several match).
- R12: When `acc_valid` is low, or a matching way is valid (a hit), all output registers keep their values and `redirect_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| man_rst | input | 1 | Manual reset request, synchronous |
| dbg_rst | input | 1 | Debug-port reset request, synchronous |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_vaddr | input | 32 | Virtual address of the access |
| cur_asid | input | 8 | Address-space ID current at the access |
| way_match | input | 4 | Per-way tag compare result |
| way_valid | input | 4 | Per-way entry valid flag |
| cur_pc | input | 32 | PC of the accessing instruction |
| cur_sr | input | 32 | Status word at the access |
| vec_base | input | 32 | Vector base address |
| fault_addr | output | 32 | Captured faulting virtual address |
| pteh | output | 32 | Page number and address-space ID image |
| saved_pc | output | 32 | Saved PC |
| saved_sr | output | 32 | Saved status word |
| event_code | output | 12 | Exception event code |
| sr_out | output | 32 | Status word after entry |
| repl_ctr | output | 2 | Way-replacement counter |
| redirect_valid | output | 1 | One-cycle redirect request |
| redirect_pc | output | 32 | Handler target address |

## Verification
Every result of a fault, and every reset request, is due at the first rising edge after the stimulus is presented: one register stage, no pipeline. The bench changes inputs on the falling edge and samples all outputs one time unit after the following rising edge, so each check sees exactly the edge that acted on its stimulus. `redirect_valid` is also checked low on the cycle after, which catches a redirect that lingers, and quiet cycles (no access or a hit) are checked for unchanged registers in the same sampling slot.

// File: rtl/mmu_fx_pkg.sv
package mmu_fx_pkg;

   typedef enum logic [1:0] {
      FX_NONE = 2'd0,
      FX_MISS = 2'd1,
      FX_INV  = 2'd2
   } fx_kind_e;

   localparam int SR_MD_POS = 30;
   localparam int SR_RB_POS = 29;
   localparam int SR_BL_POS = 28;

   function automatic logic [31:0] fx_priv_mask();
      logic [31:0] m;
      m = '0;
      m[SR_MD_POS] = 1'b1;
      m[SR_RB_POS] = 1'b1;
      m[SR_BL_POS] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/mmu_fx_classify.sv
module mmu_fx_classify
   import mmu_fx_pkg::*;
#(
   parameter int NWAYS = 4,
   localparam int WAY_W = $clog2(NWAYS)
) (
   input  logic             acc_valid,
   input  logic [NWAYS-1:0] way_match,
   input  logic [NWAYS-1:0] way_valid,
   output fx_kind_e         kind,
   output logic [WAY_W-1:0] match_idx,
   output logic [WAY_W-1:0] free_idx,
   output logic             all_valid
);

   logic [NWAYS-1:0] hit_v;
   logic [NWAYS-1:0] stale_v;

   for (genvar g = 0; g < NWAYS; g++) begin : g_way
      assign hit_v[g]   = way_match[g] &  way_valid[g];
      assign stale_v[g] = way_match[g] & ~way_valid[g];
   end

   assign all_valid = &way_valid;

   // lowest index wins: scan from the top down
   always_comb begin
      match_idx = '0;
      free_idx  = '0;
      for (int i = NWAYS - 1; i >= 0; i--) begin
         if (way_match[i]) match_idx = WAY_W'(i);
         if (!way_valid[i]) free_idx = WAY_W'(i);
      end
   end

   always_comb begin
      if (!acc_valid)        kind = FX_NONE;
      else if (~|way_match)  kind = FX_MISS;
      else if (|hit_v)       kind = FX_NONE;
      else                   kind = FX_INV;
   end

   always_comb begin
      if (kind == FX_INV)
         AST_INV_PICK: assert (stale_v[match_idx]); // R11
   end

endmodule

// File: rtl/mmu_fx_repl.sv
module mmu_fx_repl
   import mmu_fx_pkg::*;
#(
   parameter int NWAYS = 4,
   localparam int WAY_W = $clog2(NWAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_rst,
   input  fx_kind_e         kind,
   input  logic             all_valid,
   input  logic [WAY_W-1:0] free_idx,
   input  logic [WAY_W-1:0] match_idx,
   output logic [WAY_W-1:0] ctr
);

   logic [WAY_W-1:0] ctr_nx;

   always_comb begin
      ctr_nx = ctr;
      unique case (kind)
         FX_MISS: ctr_nx = all_valid ? ctr + WAY_W'(1) : free_idx;
         FX_INV:  ctr_nx = match_idx;
         default: ctr_nx = ctr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctr <= '0;
      else if (sync_rst) ctr <= '0;
      else               ctr <= ctr_nx;
   end

   AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FX_MISS && all_valid && !sync_rst) |=> ctr == $past(ctr) + WAY_W'(1)); // R9
   AST_CTR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FX_MISS && !all_valid && !sync_rst) |=> ctr == $past(free_idx)); // R10
   AST_CTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rst |=> ctr == '0); // R1

endmodule

// File: rtl/mmu_fx_ctx.sv
module mmu_fx_ctx
   import mmu_fx_pkg::*;
#(
   parameter int          VA_W       = 32,
   parameter int          ASID_W     = 8,
   parameter int          PAGE_SHIFT = 10,
   parameter int          SR_W       = 32,
   parameter int          EVT_W      = 12,
   parameter logic [31:0] MISS_OFS   = 32'h400,
   parameter logic [31:0] INV_OFS    = 32'h100,
   parameter logic [31:0] RD_CODE    = 32'h040,
   parameter logic [31:0] WR_CODE    = 32'h060
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_rst,
   input  fx_kind_e          kind,
   input  logic              acc_write,
   input  logic [VA_W-1:0]   acc_vaddr,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic [VA_W-1:0]   cur_pc,
   input  logic [SR_W-1:0]   cur_sr,
   input  logic [VA_W-1:0]   vec_base,
   output logic [VA_W-1:0]   fault_addr,
   output logic [VA_W-1:0]   pteh,
   output logic [VA_W-1:0]   saved_pc,
   output logic [SR_W-1:0]   saved_sr,
   output logic [EVT_W-1:0]  event_code,
   output logic [SR_W-1:0]   sr_out,
   output logic              redirect_valid,
   output logic [VA_W-1:0]   redirect_pc
);

   localparam logic [SR_W-1:0]  PRIV   = SR_W'(fx_priv_mask());
   localparam logic [EVT_W-1:0] EV_RD  = EVT_W'(RD_CODE);
   localparam logic [EVT_W-1:0] EV_WR  = EVT_W'(WR_CODE);
   localparam logic [VA_W-1:0]  OFS_M  = VA_W'(MISS_OFS);
   localparam logic [VA_W-1:0]  OFS_I  = VA_W'(INV_OFS);
   localparam int               GAP_W  = PAGE_SHIFT - ASID_W;

   logic              take;
   logic [VA_W-1:0]   pteh_img;

   assign take = (kind != FX_NONE);

   if (GAP_W == 0) begin : g_pteh_tight
      assign pteh_img = {acc_vaddr[VA_W-1:PAGE_SHIFT], cur_asid};
   end else begin : g_pteh_gap
      assign pteh_img = {acc_vaddr[VA_W-1:PAGE_SHIFT], {GAP_W{1'b0}}, cur_asid};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_addr     <= '0;
         pteh           <= '0;
         saved_pc       <= '0;
         saved_sr       <= '0;
         event_code     <= '0;
         sr_out         <= PRIV;
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else begin
         redirect_valid <= 1'b0;
         if (sync_rst) begin
            sr_out <= PRIV;
         end else if (take) begin
            fault_addr     <= acc_vaddr;
            pteh           <= pteh_img;
            saved_pc       <= cur_pc;
            saved_sr       <= cur_sr;
            event_code     <= acc_write ? EV_WR : EV_RD;
            sr_out         <= cur_sr | PRIV;
            redirect_valid <= 1'b1;
            redirect_pc    <= vec_base + ((kind == FX_MISS) ? OFS_M : OFS_I);
         end
      end
   end

   AST_EVT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !sync_rst) |=> event_code == ($past(acc_write) ? EV_WR : EV_RD)); // R7
   AST_SR_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (sr_out & PRIV) == PRIV); // R8
   AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !sync_rst) |=> ($stable(fault_addr) && $stable(sr_out) && !redirect_valid)); // R12
   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> !redirect_valid || $past(take)); // R2
   AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !sync_rst) |=> saved_pc == $past(cur_pc)); // R6

endmodule

// File: rtl/mmu_fault_entry.sv
module mmu_fault_entry
   import mmu_fx_pkg::*;
#(
   parameter int NWAYS      = 4,
   parameter int VA_W       = 32,
   parameter int ASID_W     = 8,
   parameter int PAGE_SHIFT = 10,
   parameter int SR_W       = 32,
   parameter int EVT_W      = 12,
   localparam int WAY_W     = $clog2(NWAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              man_rst,
   input  logic              dbg_rst,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [VA_W-1:0]   acc_vaddr,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic [NWAYS-1:0]  way_match,
   input  logic [NWAYS-1:0]  way_valid,
   input  logic [VA_W-1:0]   cur_pc,
   input  logic [SR_W-1:0]   cur_sr,
   input  logic [VA_W-1:0]   vec_base,
   output logic [VA_W-1:0]   fault_addr,
   output logic [VA_W-1:0]   pteh,
   output logic [VA_W-1:0]   saved_pc,
   output logic [SR_W-1:0]   saved_sr,
   output logic [EVT_W-1:0]  event_code,
   output logic [SR_W-1:0]   sr_out,
   output logic [WAY_W-1:0]  repl_ctr,
   output logic              redirect_valid,
   output logic [VA_W-1:0]   redirect_pc
);

   if (NWAYS < 2 || (1 << WAY_W) != NWAYS) begin : g_bad_ways
      $error("NWAYS must be a power of two, at least 2");
   end
   if (ASID_W > PAGE_SHIFT || PAGE_SHIFT >= VA_W) begin : g_bad_page
      $error("ASID_W must fit below PAGE_SHIFT, PAGE_SHIFT below VA_W");
   end
   if (SR_W <= SR_MD_POS || EVT_W < 7) begin : g_bad_sr
      $error("status word or event code too narrow");
   end

   fx_kind_e         kind;
   logic [WAY_W-1:0] match_idx;
   logic [WAY_W-1:0] free_idx;
   logic             all_valid;
   logic             sync_rst;

   assign sync_rst = man_rst | dbg_rst;

   mmu_fx_classify #(.NWAYS(NWAYS)) u_cls (
      .acc_valid (acc_valid),
      .way_match (way_match),
      .way_valid (way_valid),
      .kind      (kind),
      .match_idx (match_idx),
      .free_idx  (free_idx),
      .all_valid (all_valid)
   );

   mmu_fx_repl #(.NWAYS(NWAYS)) u_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_rst  (sync_rst),
      .kind      (kind),
      .all_valid (all_valid),
      .free_idx  (free_idx),
      .match_idx (match_idx),
      .ctr       (repl_ctr)
   );

   mmu_fx_ctx #(
      .VA_W       (VA_W),
      .ASID_W     (ASID_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .SR_W       (SR_W),
      .EVT_W      (EVT_W)
   ) u_ctx (
      .clk            (clk),
      .rst_n          (rst_n),
      .sync_rst       (sync_rst),
      .kind           (kind),
      .acc_write      (acc_write),
      .acc_vaddr      (acc_vaddr),
      .cur_asid       (cur_asid),
      .cur_pc         (cur_pc),
      .cur_sr         (cur_sr),
      .vec_base       (vec_base),
      .fault_addr     (fault_addr),
      .pteh           (pteh),
      .saved_pc       (saved_pc),
      .saved_sr       (saved_sr),
      .event_code     (event_code),
      .sr_out         (sr_out),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc)
   );

   AST_RST_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rst |=> (sr_out == SR_W'(fx_priv_mask()) && !redirect_valid)); // R1
   AST_MISS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && way_match == '0 && !sync_rst) |=> (redirect_valid && redirect_pc == $past(vec_base) + VA_W'(32'h400))); // R2

endmodule

// File: tb/tb_mmu_fault_entry.sv
module tb_mmu_fault_entry;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] PRIV = 32'h7000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        man_rst = 1'b0, dbg_rst = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [31:0] acc_vaddr = '0;
   logic [7:0]  cur_asid = '0;
   logic [3:0]  way_match = '0, way_valid = '0;
   logic [31:0] cur_pc = '0, cur_sr = '0, vec_base = '0;
   logic [31:0] fault_addr, pteh, saved_pc, saved_sr, sr_out, redirect_pc;
   logic [11:0] event_code;
   logic [1:0]  repl_ctr;
   logic        redirect_valid;

   int n_chk = 0;
   int n_bad = 0;

   // expected state
   logic [31:0] e_fa = '0, e_pteh = '0, e_spc = '0, e_ssr = '0, e_sr = PRIV, e_rpc = '0;
   logic [11:0] e_evt = '0;
   logic [1:0]  e_ctr = '0;
   logic        e_rv = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmu_fault_entry dut (
      .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .dbg_rst(dbg_rst),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_vaddr(acc_vaddr),
      .cur_asid(cur_asid), .way_match(way_match), .way_valid(way_valid),
      .cur_pc(cur_pc), .cur_sr(cur_sr), .vec_base(vec_base),
      .fault_addr(fault_addr), .pteh(pteh), .saved_pc(saved_pc),
      .saved_sr(saved_sr), .event_code(event_code), .sr_out(sr_out),
      .repl_ctr(repl_ctr), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] low_idx(input logic [3:0] v);
      for (int i = 3; i >= 0; i--) if (v[i]) low_idx = 2'(i);
      if (v == 4'd0) low_idx = 2'd0;
   endfunction

   // model the edge about to happen from the current inputs
   task automatic model_edge();
      bit miss, inv;
      miss = acc_valid && way_match == 4'd0;
      inv  = acc_valid && way_match != 4'd0 && (way_match & way_valid) == 4'd0;
      e_rv = 1'b0;
      if (man_rst || dbg_rst) begin
         e_sr = PRIV; e_ctr = 2'd0;
      end else if (miss || inv) begin
         e_fa   = acc_vaddr;
         e_pteh = {acc_vaddr[31:10], 2'b00, cur_asid};
         e_spc  = cur_pc;
         e_ssr  = cur_sr;
         e_evt  = acc_write ? 12'h060 : 12'h040;
         e_sr   = cur_sr | PRIV;
         e_rv   = 1'b1;
         e_rpc  = vec_base + (miss ? 32'h400 : 32'h100);
         if (miss) e_ctr = (way_valid == 4'hF) ? e_ctr + 2'd1 : low_idx(~way_valid);
         else      e_ctr = low_idx(way_match);
      end
   endtask

   task automatic check_all(input string tag);
      chk(fault_addr == e_fa, {tag, "/R4 fault_addr"}, fault_addr, e_fa);
      chk(pteh == e_pteh, {tag, "/R5 pteh"}, pteh, e_pteh);
      chk(saved_pc == e_spc, {tag, "/R6 saved_pc"}, saved_pc, e_spc);
      chk(saved_sr == e_ssr, {tag, "/R6 saved_sr"}, saved_sr, e_ssr);
      chk(event_code == e_evt, {tag, "/R7 event_code"}, 32'(event_code), 32'(e_evt));
      chk(sr_out == e_sr, {tag, "/R8 sr_out"}, sr_out, e_sr);
      chk(repl_ctr == e_ctr, {tag, "/R9-10-11 repl_ctr"}, 32'(repl_ctr), 32'(e_ctr));
      chk(redirect_valid == e_rv, {tag, "/R12 redirect_valid"}, 32'(redirect_valid), 32'(e_rv));
      if (e_rv) chk(redirect_pc == e_rpc, {tag, "/R2-3 redirect_pc"}, redirect_pc, e_rpc);
   endtask

   // drive on falling edge, sample just after the rising edge
   task automatic cyc(input string tag, input bit v, input bit w, input logic [31:0] va,
                      input logic [3:0] m, input logic [3:0] vl, input bit mr, input bit dr);
      @(negedge clk);
      acc_valid = v; acc_write = w; acc_vaddr = va; way_match = m; way_valid = vl;
      man_rst = mr; dbg_rst = dr;
      cur_asid = 8'($urandom); cur_pc = $urandom; cur_sr = $urandom; vec_base = $urandom & 32'hFFFF_F000;
      model_edge();
      @(posedge clk); #1;
      check_all(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      #(CLK_PERIOD * 2 + 1);
      // R1: state during power-on reset
      chk(sr_out == PRIV, "R1 sr_out in reset", sr_out, PRIV);
      chk(repl_ctr == 2'd0, "R1 repl_ctr in reset", 32'(repl_ctr), 0);
      chk(redirect_valid == 1'b0, "R1 redirect_valid in reset", 32'(redirect_valid), 0);
      @(negedge clk); rst_n = 1'b1;

      // directed corners
      cyc("R12 no access", 1'b0, 1'b0, 32'h1234_5678, 4'd0, 4'd0, 1'b0, 1'b0);
      cyc("R2 miss read free0", 1'b1, 1'b0, 32'hDEAD_BEEF, 4'd0, 4'b1110, 1'b0, 1'b0);
      cyc("R12 pulse ends", 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 1'b0, 1'b0);
      cyc("R10 miss free2", 1'b1, 1'b1, 32'hCAFE_0400, 4'd0, 4'b1011, 1'b0, 1'b0);
      cyc("R9 miss all valid", 1'b1, 1'b0, 32'h0000_0C00, 4'd0, 4'hF, 1'b0, 1'b0);
      cyc("R9 miss wrap 3->0", 1'b1, 1'b1, 32'hFFFF_FFFF, 4'd0, 4'hF, 1'b0, 1'b0);
      cyc("R11 inv way2", 1'b1, 1'b0, 32'h8000_1234, 4'b0100, 4'b1011, 1'b0, 1'b0);
      cyc("R3 inv way3 write", 1'b1, 1'b1, 32'h4000_03FF, 4'b1000, 4'b0111, 1'b0, 1'b0);
      cyc("R12 hit way1", 1'b1, 1'b1, 32'h5555_AAAA, 4'b0010, 4'hF, 1'b0, 1'b0);
      cyc("R1 manual reset", 1'b1, 1'b0, 32'h1111_2222, 4'd0, 4'hF, 1'b1, 1'b0);
      cyc("R2 miss after reset", 1'b1, 1'b0, 32'h2222_3333, 4'd0, 4'b0111, 1'b0, 1'b0);
      cyc("R1 debug reset", 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 1'b0, 1'b1);

      // constrained random mix
      for (int k = 0; k < 400; k++) begin
         int sel;
         logic [3:0] m, vl;
         int w;
         sel = int'($urandom % 10);
         w   = int'($urandom % 4);
         vl  = 4'($urandom);
         m   = 4'd0;
         case (sel)
            0: begin m = 4'($urandom); cyc("R12 rand idle", 1'b0, 1'($urandom), $urandom, m, vl, 1'b0, 1'b0); end
            1, 2: begin m[w] = 1'b1; vl[w] = 1'b1; cyc("R12 rand hit", 1'b1, 1'($urandom), $urandom, m, vl, 1'b0, 1'b0); end
            3, 4: cyc("R2 rand miss", 1'b1, 1'($urandom), $urandom, 4'd0, vl, 1'b0, 1'b0);
            5: cyc("R9 rand miss full", 1'b1, 1'($urandom), $urandom, 4'd0, 4'hF, 1'b0, 1'b0);
            6, 7: begin m[w] = 1'b1; vl[w] = 1'b0; cyc("R3 rand inv", 1'b1, 1'($urandom), $urandom, m, vl, 1'b0, 1'b0); end
            8: cyc("R1 rand reset req", 1'b1, 1'($urandom), $urandom, 4'd0, vl, 1'($urandom), 1'b1);
            default: cyc("R12 rand quiet", 1'b0, 1'b0, $urandom, 4'd0, vl, 1'b0, 1'b0);
         endcase
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule